// File: doc/BRIEF.md
# Fragment Program Stream Validator

The validator watches a pixel-shader program as it streams past, one 32-bit word per accepted transfer, three words to an instruction. Each instruction is decoded once its third word arrives. The block checks the instruction against the architectural program rules, using state it keeps for the whole program: which interpolated inputs and samplers have been declared, which temporaries hold a written value, and which outputs a texture fetch has already written in the current phase.

The block does not execute, sample or compute anything. It only judges the program. When the word marked last has been accepted, the block raises `done`. At the same time it raises either `pass` or a nonzero error code that names the first rule broken, together with the zero-based index of the instruction that broke it. The verdict holds until reset, and the block accepts nothing more until then. A new program therefore starts with a reset.

Top module: `shader_prog_validator`

## Requirements
- R1: `in_ready` is high from reset until `done`. A word is accepted on a clock edge where `in_valid` and `in_ready` are both high. `done` rises on the edge after the word with `in_last` set is accepted. After that, `done` stays high and `in_ready` stays low, and words offered on the input change no output.
- R2: `pass` is high exactly when `done` is high and no violation has been found. `err_code` is 0 while no violation has been found.
- R3: The first violation sets `err_code` and `err_index`, and both then hold until reset. When one instruction breaks several rules, the lowest code among them is reported.
- R4: The opcode is word 0 bits 31:24. Arithmetic opcodes are 0x00–0x14 (0x00 is a no-op), texture opcodes are 0x15–0x18 (0x18 is the pixel-kill test), and 0x19 is a declaration. Any opcode above 0x19 gives code 1.
- R5: The destination type is word 0 bits 21:19 and its number is bits 17:14. Register type codes are: 0 preserved temporary, 1 interpolated input, 2 constant, 3 sampler, 4 output color, 5 output depth, 6 unpreserved temporary. Every arithmetic opcode except the no-op, and every texture opcode except the kill test, must name a preserved temporary 0..15, output color 0, output depth 0 or an unpreserved temporary 0..2. Any other destination gives code 3.
- R6: Sources are placed as follows: source 0 in word 0 (type 9:7, number 5:2), source 1 in word 1 (type 15:13, number 11:8), source 2 in word 2 (type 23:21, number 19:16). The texture address is in word 1 (type 26:24, number 20:17). An arithmetic source that is read must be a preserved temporary 0..15, an input 0..10, a constant 0..15, output color or depth 0, or an unpreserved temporary 0..2. A texture address must be a preserved temporary, an input, or output color or depth. Any other source gives code 4.
- R7: A declaration of an input must use a number 0..10 and a channel mask (word 0 bits 13:10) of 0x1, 0x3, 0x7, 0x8 or 0xF. A declaration of a sampler must use a mask of 0. Any other type, or a nonzero word 1 or word 2, gives code 2.
- R8: An input read as a source, or a sampler named by a texture opcode other than the kill test (word 0 bits 3:0), must have been declared by an earlier instruction. Otherwise the code is 5.
- R9: Arithmetic opcodes read these sources: source 0 for 0x01–0x14; source 1 for 0x01, 0x03–0x07, 0x0D–0x0F, 0x13 and 0x14; source 2 for 0x04, 0x05 and 0x0D. A preserved or unpreserved temporary that is read must have been written by an earlier instruction, through a texture destination or an arithmetic destination with a nonzero mask. Otherwise the code is 6.
- R10: If the sources read by one instruction reference two different constant numbers, the code is 7. The same constant may be read in several slots.
- R11: A texture instruction whose address type is not an input starts a new phase. At that point, unpreserved temporaries lose their written status and the per-phase output record is cleared. Preserved temporaries keep their written status.
- R12: Within a phase, a second texture destination of output color, or a second texture destination of output depth, gives code 8. Arithmetic writes to these outputs are not limited.
- R13: If the last word ends an incomplete instruction, the code is 9 and the index is that of the incomplete instruction.
- R14: The first word of a 124th instruction (index 123) gives code 10 with index 123. A program of 123 instructions is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Program word offered |
| in_ready | output | 1 | Block can accept a word |
| in_word | input | 32 | Program word |
| in_last | input | 1 | Offered word is the final word |
| done | output | 1 | Verdict available |
| pass | output | 1 | Program obeys every rule |
| err_code | output | 4 | First violation code, 0 for none |
| err_index | output | 7 | Index of the instruction with the first violation |

## Verification
The checker module watches the handshake and verdict rules on every cycle. It checks that `done` is sticky and blocks further input, that `done` appears only right after a last word, that `pass` never coexists with an error, that a reported error never changes, and that the reported index stays in bounds. Whether the decode applies each rule correctly can only be shown by the bench's programs. These are sweeps over every destination type and number, every source type and number, and every declaration type, number and mask. Targeted programs cover phase boundaries created by dependent reads, repeated output fetches, constant conflicts, truncated streams, the 123-instruction limit and the ordering of simultaneous faults.

// File: rtl/shader_prog_validator.sv
module shader_prog_validator #(
  parameter int MAX_INSNS = 123,
  parameter int NUM_R = 16,
  parameter int NUM_T = 11,
  parameter int NUM_S = 16,
  parameter int NUM_C = 16,
  parameter int NUM_U = 3,
  localparam int IW = $clog2(MAX_INSNS + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [31:0]   in_word,
  input  logic          in_last,
  output logic          done,
  output logic          pass,
  output logic [3:0]    err_code,
  output logic [IW-1:0] err_index
);
  localparam logic [2:0] TY_R = 3'd0, TY_T = 3'd1, TY_C = 3'd2, TY_S = 3'd3,
                         TY_OC = 3'd4, TY_OD = 3'd5, TY_U = 3'd6;

  logic [1:0]    wcnt;
  logic [31:0]   w0, w1;
  logic [IW-1:0] idx, eidx_r;
  logic [15:0]   r_wr, u_wr, t_dcl, s_dcl;
  logic          oc_tex, od_tex, done_r;
  logic [3:0]    code_r, ins_code;

  wire        acc      = in_valid && in_ready;
  wire [31:0] w2       = in_word;
  wire        insn_end = acc && wcnt == 2'd2;
  wire        unused_ok = &{1'b0, w0[23:22], w0[6], w0[1:0]};

  wire [7:0] op       = w0[31:24];
  wire       is_arith = op <= 8'h14;
  wire       is_tex   = op >= 8'h15 && op <= 8'h18;
  wire       is_kill  = op == 8'h18;
  wire       is_dcl   = op == 8'h19;
  wire       bad_op   = op > 8'h19;
  wire [2:0] dtype    = w0[21:19];
  wire [3:0] dnr      = w0[17:14];
  wire [3:0] dmask    = w0[13:10];
  wire [2:0] atype    = w1[26:24];
  wire [3:0] anr      = w1[20:17];
  wire       has_dest = (is_arith && op != 8'h00) || (is_tex && !is_kill);
  wire       dep      = is_tex && atype != TY_T;
  wire       tex_wr   = is_tex && !is_kill;

  function automatic logic dest_ok(input logic [2:0] t, input logic [3:0] n);
    case (t)
      TY_R:         return int'(n) < NUM_R;
      TY_OC, TY_OD: return n == 4'd0;
      TY_U:         return int'(n) < NUM_U;
      default:      return 1'b0;
    endcase
  endfunction

  function automatic logic src_ok(input logic [2:0] t, input logic [3:0] n, input logic tex);
    case (t)
      TY_R:         return int'(n) < NUM_R;
      TY_T:         return int'(n) < NUM_T;
      TY_C:         return !tex && int'(n) < NUM_C;
      TY_OC, TY_OD: return n == 4'd0;
      TY_U:         return !tex && int'(n) < NUM_U;
      default:      return 1'b0;
    endcase
  endfunction

  logic [2:0] st [3];
  logic [3:0] sn [3];
  logic       su [3];
  logic       e_src, e_undecl, e_unwr, e_const, e_dest, e_dcl, e_out, dcl_fmt;

  always_comb begin
    st[0] = w0[9:7];   sn[0] = w0[5:2];
    st[1] = w1[15:13]; sn[1] = w1[11:8];
    st[2] = w2[23:21]; sn[2] = w2[19:16];
    su[0] = is_arith && op != 8'h00;
    su[1] = is_arith && (op == 8'h01 || (op >= 8'h03 && op <= 8'h07) ||
                         (op >= 8'h0d && op <= 8'h0f) || op == 8'h13 || op == 8'h14);
    su[2] = op == 8'h04 || op == 8'h05 || op == 8'h0d;
    if (is_tex) begin
      st[0] = atype; sn[0] = anr;
      su[0] = 1'b1; su[1] = 1'b0; su[2] = 1'b0;
    end
    e_src = 1'b0; e_undecl = 1'b0; e_unwr = 1'b0; e_const = 1'b0;
    for (int k = 0; k < 3; k++) begin
      if (su[k]) begin
        if (!src_ok(st[k], sn[k], is_tex)) e_src = 1'b1;
        if (st[k] == TY_T && !t_dcl[sn[k]]) e_undecl = 1'b1;
        if (st[k] == TY_R && !r_wr[sn[k]]) e_unwr = 1'b1;
        if (st[k] == TY_U && !u_wr[sn[k]]) e_unwr = 1'b1;
        for (int j = 0; j < k; j++)
          if (su[j] && st[j] == TY_C && st[k] == TY_C && sn[j] != sn[k]) e_const = 1'b1;
      end
    end
    if (tex_wr && !s_dcl[w0[3:0]]) e_undecl = 1'b1;
    e_dest  = has_dest && !dest_ok(dtype, dnr);
    e_out   = tex_wr && !dep && ((dtype == TY_OC && oc_tex) || (dtype == TY_OD && od_tex));
    dcl_fmt = (dtype == TY_T && int'(dnr) < NUM_T &&
               (dmask == 4'h1 || dmask == 4'h3 || dmask == 4'h7 || dmask == 4'h8 || dmask == 4'hf)) ||
              (dtype == TY_S && int'(dnr) < NUM_S && dmask == 4'h0);
    e_dcl   = is_dcl && (!dcl_fmt || w1 != 32'd0 || w2 != 32'd0);
    ins_code = bad_op   ? 4'd1 : e_dcl  ? 4'd2 : e_dest  ? 4'd3 : e_src ? 4'd4 :
               e_undecl ? 4'd5 : e_unwr ? 4'd6 : e_const ? 4'd7 : e_out ? 4'd8 : 4'd0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt <= '0; w0 <= '0; w1 <= '0; idx <= '0; eidx_r <= '0; code_r <= '0;
      r_wr <= '0; u_wr <= '0; t_dcl <= '0; s_dcl <= '0;
      oc_tex <= 1'b0; od_tex <= 1'b0; done_r <= 1'b0;
    end else if (acc) begin
      if (wcnt == 2'd0) w0 <= in_word;
      if (wcnt == 2'd1) w1 <= in_word;
      wcnt <= (wcnt == 2'd2 || in_last) ? 2'd0 : wcnt + 2'd1;
      if (in_last) done_r <= 1'b1;
      if (code_r == 4'd0) begin
        if (wcnt == 2'd0 && int'(idx) >= MAX_INSNS) begin
          code_r <= 4'd10; eidx_r <= idx;
        end else if (insn_end && ins_code != 4'd0) begin
          code_r <= ins_code; eidx_r <= idx;
        end else if (in_last && wcnt != 2'd2) begin
          code_r <= 4'd9; eidx_r <= idx;
        end
      end
      if (insn_end) begin
        if (int'(idx) < MAX_INSNS) idx <= idx + 1'b1;
        if (dep) begin
          u_wr <= '0; oc_tex <= 1'b0; od_tex <= 1'b0;
        end
        if (has_dest && (is_tex || dmask != 4'h0)) begin
          if (dtype == TY_R) r_wr[dnr] <= 1'b1;
          if (dtype == TY_U) u_wr[dnr] <= 1'b1;
        end
        if (tex_wr && dtype == TY_OC) oc_tex <= 1'b1;
        if (tex_wr && dtype == TY_OD) od_tex <= 1'b1;
        if (is_dcl && !e_dcl && dtype == TY_T) t_dcl[dnr] <= 1'b1;
        if (is_dcl && !e_dcl && dtype == TY_S) s_dcl[dnr] <= 1'b1;
      end
    end
  end

  assign in_ready  = !done_r;
  assign done      = done_r;
  assign pass      = done_r && code_r == 4'd0;
  assign err_code  = code_r;
  assign err_index = eidx_r;
endmodule

// File: rtl/shader_prog_validator_chk.sv
module shader_prog_validator_chk #(
  parameter int MAX_INSNS = 123,
  localparam int IW = $clog2(MAX_INSNS + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic          in_last,
  input logic          done,
  input logic          pass,
  input logic [3:0]    err_code,
  input logic [IW-1:0] err_index
);
  p_done_sticky_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
  p_ready_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !in_ready);
  p_done_after_last_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(in_valid && in_ready && in_last));
  p_pass_clean_r2: assert property (@(posedge clk) disable iff (!rst_n)
    pass |-> (done && err_code == 4'd0));
  p_err_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code != 4'd0) |=> ($stable(err_code) && $stable(err_index)));
  p_no_index_clean_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (err_code == 4'd0) |-> (err_index == '0));
  p_index_bound_r14: assert property (@(posedge clk) disable iff (!rst_n)
    int'(err_index) <= MAX_INSNS);
endmodule

bind shader_prog_validator shader_prog_validator_chk #(.MAX_INSNS(MAX_INSNS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .in_last(in_last), .done(done), .pass(pass), .err_code(err_code),
  .err_index(err_index)
);

// File: tb/sim_shader_prog_validator.sv
`timescale 1ns/1ps
module sim_shader_prog_validator;
  logic clk = 1'b0, rst_n = 1'b0, in_valid = 1'b0, in_last = 1'b0;
  logic [31:0] in_word = '0;
  logic in_ready, done, pass;
  logic [3:0] err_code;
  logic [6:0] err_index;
  int checks = 0, errors = 0;
  logic [31:0] prog [0:399];
  int plen = 0;

  localparam int R = 0, T = 1, C = 2, S = 3, OC = 4, OD = 5, U = 6;
  localparam int NOP = 0, MOV = 2, MUL = 3, MAD = 4, TEX = 21, KILL = 24;

  always #10 clk = ~clk;

  shader_prog_validator u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_word(in_word), .in_last(in_last), .done(done), .pass(pass),
    .err_code(err_code), .err_index(err_index));

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: got %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic put(input logic [31:0] a, input logic [31:0] b, input logic [31:0] c);
    prog[plen] = a; prog[plen+1] = b; prog[plen+2] = c; plen += 3;
  endtask
  task automatic ar(input int op, input int dt, input int dn, input int m,
                    input int at, input int an, input int bt, input int bn, input int ct, input int cn);
    put(32'((op << 24) | (dt << 19) | (dn << 14) | (m << 10) | (at << 7) | (an << 2)),
        32'((bt << 13) | (bn << 8)), 32'((ct << 21) | (cn << 16)));
  endtask
  task automatic mov(input int dt, input int dn, input int at, input int an);
    ar(MOV, dt, dn, 15, at, an, 0, 0, 0, 0);
  endtask
  task automatic tx(input int op, input int dt, input int dn, input int smp, input int at, input int an);
    put(32'((op << 24) | (dt << 19) | (dn << 14) | smp), 32'((at << 24) | (an << 17)), 32'd0);
  endtask
  task automatic dc(input int t, input int n, input int m);
    put(32'((25 << 24) | (t << 19) | (n << 14) | (m << 10)), 32'd0, 32'd0);
  endtask

  task automatic do_reset;
    @(negedge clk); rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0;
    @(negedge clk); @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic go(input int ecode, input int eidx, input string tag, input bit gaps = 1'b0);
    do_reset();
    for (int i = 0; i < plen; i++) begin
      if (gaps && (i % 2 == 1)) begin in_valid = 1'b0; @(negedge clk); end
      in_valid = 1'b1; in_word = prog[i]; in_last = (i == plen - 1);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    check({tag, " R1 done"}, int'(done), 1);
    check({tag, " R2 pass"}, int'(pass), int'(ecode == 0));
    check({tag, " err_code"}, int'(err_code), ecode);
    check({tag, " err_index"}, int'(err_index), eidx);
    plen = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got 0 expected 1");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    do_reset();
    check("R1 reset ready", int'(in_ready), 1);
    check("R1 reset done", int'(done), 0);
    check("R2 reset pass", int'(pass), 0);
    check("R2 reset code", int'(err_code), 0);

    // R1: verdict holds and later words are ignored
    mov(R, 0, C, 0); go(0, 0, "R1 single");
    check("R1 ready low", int'(in_ready), 0);
    in_valid = 1'b1; in_word = 32'hFF00_0000; in_last = 1'b1;
    repeat (4) @(negedge clk);
    in_valid = 1'b0; in_last = 1'b0;
    check("R1 ignored done", int'(done), 1);
    check("R1 ignored pass", int'(pass), 1);
    check("R1 ignored code", int'(err_code), 0);

    // R5 destination sweep
    for (int t = 0; t < 8; t++)
      for (int n = 0; n < 16; n++) begin
        automatic bit ok = (t == R) || ((t == OC || t == OD) && n == 0) || (t == U && n < 3);
        mov(t, n, C, 0);
        go(ok ? 0 : 3, 0, "R5 dest sweep");
      end

    // R6 R8 R9 source sweep
    for (int t = 0; t < 8; t++)
      for (int n = 0; n < 16; n++) begin
        automatic int e;
        case (t)
          R:       e = (n == 0) ? 0 : 6;
          T:       e = (n <= 10) ? 0 : 4;
          C:       e = 0;
          OC, OD:  e = (n == 0) ? 0 : 4;
          U:       e = (n < 3) ? 6 : 4;
          default: e = 4;
        endcase
        for (int k = 0; k < 11; k++) dc(T, k, 15);
        mov(R, 0, C, 0);
        mov(R, 1, t, n);
        go(e, e == 0 ? 0 : 12, "R6 source sweep");
      end

    // R7 declaration sweep
    for (int n = 0; n < 16; n++)
      for (int m = 0; m < 16; m++) begin
        automatic bit okt = n <= 10 && (m == 1 || m == 3 || m == 7 || m == 8 || m == 15);
        dc(T, n, m); go(okt ? 0 : 2, 0, "R7 input dcl sweep");
        dc(S, n, m); go(m == 0 ? 0 : 2, 0, "R7 sampler dcl sweep");
      end
    dc(R, 0, 15); go(2, 0, "R7 dcl bad type");
    put(32'((25 << 24) | (1 << 19) | (15 << 10)), 32'd1, 32'd0); go(2, 0, "R7 dcl word1 nonzero");
    put(32'((25 << 24) | (1 << 19) | (15 << 10)), 32'd0, 32'h100); go(2, 0, "R7 dcl word2 nonzero");

    // R4 opcode
    mov(R, 0, C, 0); put(32'h1A00_0000, 0, 0); go(1, 1, "R4 bad opcode");
    put(32'hFF00_0000, 0, 0); go(1, 0, "R4 opcode ff");

    // R10 constants
    ar(MUL, R, 0, 15, C, 0, C, 1, 0, 0); go(7, 0, "R10 two constants");
    ar(MUL, R, 0, 15, C, 2, C, 2, 0, 0); go(0, 0, "R10 same constant");
    ar(MAD, R, 0, 15, C, 1, C, 1, C, 3); go(7, 0, "R10 third slot");
    ar(MOV, R, 0, 15, C, 1, C, 4, C, 5); go(0, 0, "R10 unread slots");

    // R8 samplers and texture addresses
    dc(T, 0, 15); tx(TEX, R, 0, 0, T, 0); go(5, 1, "R8 sampler undeclared");
    dc(T, 0, 15); dc(S, 0, 0); tx(TEX, R, 0, 0, T, 0); go(0, 0, "R8 sampler declared");
    dc(T, 0, 15); tx(KILL, R, 0, 5, T, 0); go(0, 0, "R8 kill ignores sampler");
    dc(S, 0, 0); tx(TEX, R, 0, 0, T, 1); go(5, 1, "R8 address undeclared");
    dc(S, 0, 0); tx(TEX, R, 0, 0, C, 0); go(4, 1, "R6 const address");

    // R9 write before read
    mov(R, 1, R, 2); go(6, 0, "R9 unwritten");
    mov(R, 2, C, 0); mov(R, 1, R, 2); go(0, 0, "R9 written");
    mov(R, 3, R, 3); go(6, 0, "R9 self read");
    ar(MOV, R, 4, 0, C, 0, 0, 0, 0, 0); mov(R, 1, R, 4); go(6, 1, "R9 zero mask");

    // R11 phases
    dc(T, 0, 15); dc(S, 0, 0); mov(U, 0, C, 0); tx(TEX, R, 0, 0, T, 0); mov(R, 1, U, 0);
    go(0, 0, "R11 plain fetch keeps phase");
    dc(T, 0, 15); dc(S, 0, 0); mov(U, 0, C, 0); mov(R, 0, C, 0); tx(TEX, R, 1, 0, R, 0); mov(R, 2, U, 0);
    go(6, 5, "R11 dependent read clears");
    dc(T, 0, 15); dc(S, 0, 0); mov(R, 0, C, 0); tx(TEX, R, 1, 0, R, 0); mov(R, 2, R, 0);
    go(0, 0, "R11 preserved survive");

    // R12 outputs per phase
    dc(T, 0, 15); dc(S, 0, 0); tx(TEX, OC, 0, 0, T, 0); tx(TEX, OC, 0, 0, T, 0);
    go(8, 3, "R12 color twice");
    dc(T, 0, 15); dc(S, 0, 0); tx(TEX, OD, 0, 0, T, 0); tx(TEX, OD, 0, 0, T, 0);
    go(8, 3, "R12 depth twice");
    dc(T, 0, 15); dc(S, 0, 0); tx(TEX, OC, 0, 0, T, 0); tx(TEX, OD, 0, 0, T, 0);
    go(0, 0, "R12 color and depth");
    dc(T, 0, 15); dc(S, 0, 0); tx(TEX, OC, 0, 0, T, 0); mov(R, 0, C, 0);
    tx(TEX, R, 1, 0, R, 0); tx(TEX, OC, 0, 0, T, 0);
    go(0, 0, "R12 new phase allows");
    mov(OC, 0, C, 0); mov(OC, 0, C, 1); go(0, 0, "R12 arith unlimited");

    // R13 length
    mov(R, 0, C, 0); prog[plen] = 0; plen++; go(9, 1, "R13 one extra word");
    prog[0] = 0; prog[1] = 0; plen = 2; go(9, 0, "R13 two words");

    // R14 instruction limit
    for (int i = 0; i < 123; i++) put(0, 0, 0);
    go(0, 0, "R14 123 instructions");
    for (int i = 0; i < 124; i++) put(0, 0, 0);
    go(10, 123, "R14 124 instructions");

    // R3 first violation and priority
    mov(R, 1, R, 2); put(32'h1A00_0000, 0, 0); go(6, 0, "R3 first kept");
    mov(T, 0, R, 5); go(3, 0, "R3 lowest code");
    mov(R, 0, C, 0); ar(MUL, R, 1, 15, C, 0, C, 1, 0, 0); prog[plen] = 0; plen++;
    go(7, 1, "R3 over length");

    // R1 with idle gaps
    dc(T, 0, 15); dc(S, 0, 0); tx(TEX, R, 0, 0, T, 0); mov(OC, 0, R, 0);
    go(0, 0, "R1 gaps pass", 1'b1);
    dc(T, 0, 15); mov(R, 0, T, 3); go(5, 1, "R1 gaps error", 1'b1);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule